// File: doc/BRIEF.md
# Protection Entry Permission Checker

This block judges a single memory-protection entry against one access. It receives the entry's 8-bit configuration byte, a match flag produced by a separate address comparator, a one-hot access kind (load, store/AMO or instruction fetch) and a flag telling whether the hart runs in machine mode. From these it reports whether the entry governs the access at all (`applies_o`) and whether the access must be refused with an access fault (`fault_o`). Both results are registered, so they appear one clock after the inputs.

Accesses from privilege levels below machine mode are checked by every enabled, matching entry. Machine-mode accesses are checked only by entries whose lock bit is set. Otherwise the entry stays silent. An entry whose address-mode field is zero is switched off and never governs anything. Address range comparison and arbitration among several entries happen outside this block, and the match flag is taken as given.

Top module: `pmp_perm_check`

## Requirements
- R1: A fetch (access bit 2) that the entry governs faults when configuration bit 2 (execute permission) is 0.
- R2: A store/AMO (access bit 1) that the entry governs faults when configuration bit 1 (write permission) is 0.
- R3: A load (access bit 0) that the entry governs faults when configuration bit 0 (read permission) is 0.
- R4: A governed access whose matching permission bit is 1 does not fault.
- R5: When the privilege flag is 0 (below machine mode), the match flag is 1 and bits 4:3 (address mode) are nonzero, `applies_o` is 1, whatever bit 7 holds.
- R6: With the privilege flag 1 (machine mode) and bit 7 (lock) equal to 0, `applies_o` and `fault_o` are both 0.
- R7: With the privilege flag 1 and bit 7 equal to 1, the entry is checked exactly as it is for lower privilege.
- R8: With bits 4:3 equal to 0 (entry off), `applies_o` and `fault_o` are both 0.
- R9: With the match flag 0, `applies_o` and `fault_o` are both 0.
- R10: If the access vector does not have exactly one bit set, `fault_o` is 0. `applies_o` is still decided by R5 to R9.
- R11: Configuration bits 6:5 have no effect on either output.
- R12: Both outputs are 0 during reset and reflect the inputs sampled at a rising clock edge from that edge on, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_i | input | 8 | Entry configuration byte: bit 7 lock, 6:5 reserved, 4:3 address mode, 2 X, 1 W, 0 R |
| match_i | input | 1 | Address comparator reports a hit on this entry |
| acc_i | input | 3 | One-hot access kind: bit 0 load, bit 1 store/AMO, bit 2 fetch |
| priv_m_i | input | 1 | 1 when the access comes from machine mode |
| applies_o | output | 1 | The entry governs this access (registered) |
| fault_o | output | 1 | The access must raise an access fault (registered) |

## Verification
The only state is the registered result pair, so any corruption appears on the ports within one clock of the offending inputs. A bad lock gate would raise `applies_o` for unlocked machine-mode accesses on the very next cycle. A wrong permission lane would mark a fault on a single access kind while its neighbours look correct. Because of that, every combination of the permission bits, lock, address mode, reserved bits, privilege, match and all eight access vectors is applied and compared with a model, and the model's cases are attributed to the requirement they exercise.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

    localparam int CFG_W   = 8;
    localparam int NUM_ACC = 3;

    // Access-vector lanes line up with the permission bits they consult.
    localparam int ACC_LOAD  = 0;
    localparam int ACC_STORE = 1;
    localparam int ACC_FETCH = 2;

    typedef enum logic [1:0] {
        AMODE_OFF   = 2'd0,
        AMODE_TOR   = 2'd1,
        AMODE_NA4   = 2'd2,
        AMODE_NAPOT = 2'd3
    } amode_e;

    typedef struct packed {
        logic                 lock;
        logic [1:0]           rsvd;
        amode_e               amode;
        logic [NUM_ACC-1:0]   perm;   // {X, W, R}
    } entry_cfg_t;

    typedef struct packed {
        logic applies;
        logic fault;
    } verdict_t;

endpackage

// File: rtl/pmp_cfg_unpack.sv
module pmp_cfg_unpack
    import pmp_chk_pkg::*;
(
    input  logic [CFG_W-1:0]   cfg_byte,
    output logic               lock,
    output logic               enabled,
    output logic [NUM_ACC-1:0] perm
);
    entry_cfg_t fields;
    logic       unused_rsvd;

    always_comb begin
        fields      = entry_cfg_t'(cfg_byte);
        lock        = fields.lock;
        enabled     = (fields.amode != AMODE_OFF);
        perm        = fields.perm;
        unused_rsvd = ^fields.rsvd;
    end
endmodule

// File: rtl/pmp_perm_pick.sv
module pmp_perm_pick
    import pmp_chk_pkg::*;
#(
    parameter int LANES = NUM_ACC
) (
    input  logic [LANES-1:0] acc,
    input  logic [LANES-1:0] perm,
    output logic             acc_valid,
    output logic             granted
);
    logic [LANES-1:0] lane_ok;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ok[g] = acc[g] & perm[g];
    end

    always_comb begin
        acc_valid = $onehot(acc);
        granted   = |lane_ok;
    end
endmodule

// File: rtl/pmp_priv_gate.sv
module pmp_priv_gate (
    input  logic match,
    input  logic enabled,
    input  logic lock,
    input  logic priv_m,
    output logic applies
);
    always_comb begin
        applies = match & enabled & (~priv_m | lock);
    end
endmodule

// File: rtl/pmp_perm_check.sv
module pmp_perm_check
    import pmp_chk_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CFG_W-1:0]   cfg_i,
    input  logic               match_i,
    input  logic [NUM_ACC-1:0] acc_i,
    input  logic               priv_m_i,
    output logic               applies_o,
    output logic               fault_o
);
    logic               lock_w;
    logic               enabled_w;
    logic [NUM_ACC-1:0] perm_w;
    logic               acc_valid_w;
    logic               granted_w;
    logic               applies_w;

    verdict_t verdict_d, verdict_q;

    pmp_cfg_unpack u_unpack (
        .cfg_byte (cfg_i),
        .lock     (lock_w),
        .enabled  (enabled_w),
        .perm     (perm_w)
    );

    pmp_perm_pick #(.LANES(NUM_ACC)) u_pick (
        .acc       (acc_i),
        .perm      (perm_w),
        .acc_valid (acc_valid_w),
        .granted   (granted_w)
    );

    pmp_priv_gate u_gate (
        .match   (match_i),
        .enabled (enabled_w),
        .lock    (lock_w),
        .priv_m  (priv_m_i),
        .applies (applies_w)
    );

    always_comb begin
        verdict_d         = verdict_q;
        verdict_d.applies = applies_w;
        verdict_d.fault   = applies_w & acc_valid_w & ~granted_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_q <= '0;
        end else begin
            verdict_q <= verdict_d;
        end
    end

    assign applies_o = verdict_q.applies;
    assign fault_o   = verdict_q.fault;
endmodule

// File: rtl/pmp_perm_check_sva.sv
module pmp_perm_check_sva
    import pmp_chk_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [CFG_W-1:0]   cfg_i,
    input logic               match_i,
    input logic [NUM_ACC-1:0] acc_i,
    input logic               priv_m_i,
    input logic               applies_o,
    input logic               fault_o
);
    a_r7_fault_needs_applies: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> applies_o);

    a_r9_no_match_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !match_i |=> (!applies_o && !fault_o));

    a_r8_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[4:3] == 2'b00) |=> (!applies_o && !fault_o));

    a_r6_unlocked_machine_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_m_i && !cfg_i[7]) |=> (!applies_o && !fault_o));

    a_r10_bad_vector_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(acc_i) != 1) |=> !fault_o);

    a_r5_lower_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv_m_i && match_i && cfg_i[4:3] != 2'b00) |=> applies_o);

    a_r1_fetch_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (!priv_m_i && match_i && cfg_i[4:3] != 2'b00 && acc_i == 3'b100 && !cfg_i[2])
        |=> fault_o);

    a_r4_granted_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(acc_i) == 1 && (acc_i & cfg_i[2:0]) != 3'b000) |=> !fault_o);
endmodule

bind pmp_perm_check pmp_perm_check_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_i     (cfg_i),
    .match_i   (match_i),
    .acc_i     (acc_i),
    .priv_m_i  (priv_m_i),
    .applies_o (applies_o),
    .fault_o   (fault_o)
);

// File: tb/tb_pmp_perm_check.sv
module tb_pmp_perm_check;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_i = '0;
    logic       match_i = 1'b0;
    logic [2:0] acc_i = '0;
    logic       priv_m_i = 1'b0;
    logic       applies_o;
    logic       fault_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pmp_perm_check dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_i     (cfg_i),
        .match_i   (match_i),
        .acc_i     (acc_i),
        .priv_m_i  (priv_m_i),
        .applies_o (applies_o),
        .fault_o   (fault_o)
    );

    function automatic void model(input logic [7:0] c, input logic m, input logic [2:0] a,
                                  input logic pm, output logic app, output logic flt);
        logic on1;
        on1 = (a == 3'b001) || (a == 3'b010) || (a == 3'b100);
        app = m && (c[4:3] != 2'b00) && (!pm || c[7]);
        flt = app && on1 && ((a == 3'b001 && !c[0]) || (a == 3'b010 && !c[1]) ||
                             (a == 3'b100 && !c[2]));
    endfunction

    function automatic string tag_of(input logic [7:0] c, input logic m, input logic [2:0] a,
                                     input logic pm);
        if (!m) return "R9";
        if (c[4:3] == 2'b00) return "R8";
        if (pm && !c[7]) return "R6";
        if (!(a == 3'b001 || a == 3'b010 || a == 3'b100)) return "R10";
        if (pm) return "R7";
        if (a == 3'b100) return c[2] ? "R4" : "R1";
        if (a == 3'b010) return c[1] ? "R4" : "R2";
        return c[0] ? "R4" : "R3";
    endfunction

    task automatic check(input string req, input logic got_a, input logic got_f,
                         input logic exp_a, input logic exp_f);
        n_vec++;
        if (got_a !== exp_a || got_f !== exp_f) begin
            n_fail++;
            $display("FAIL %s: applies/fault = %b%b, expected %b%b", req, got_a, got_f,
                     exp_a, exp_f);
        end
    endtask

    // Drive at a falling edge, result is registered at the next rising edge
    // and sampled at the falling edge after it.
    task automatic apply(input logic [7:0] c, input logic m, input logic [2:0] a,
                         input logic pm, input string req);
        logic ea, ef;
        cfg_i = c; match_i = m; acc_i = a; priv_m_i = pm;
        model(c, m, a, pm, ea, ef);
        @(negedge clk);
        check(req, applies_o, fault_o, ea, ef);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        cfg_i = 8'h98; match_i = 1'b1; acc_i = 3'b100; priv_m_i = 1'b0;
        repeat (3) @(negedge clk);
        check("R12", applies_o, fault_o, 1'b0, 1'b0);
        rst_n = 1'b1;
        cfg_i = 8'h00; match_i = 1'b0; acc_i = 3'b000;
        @(negedge clk);
        check("R12", applies_o, fault_o, 1'b0, 1'b0);
    endtask

    task automatic t_latency;
        // Execute denied, lower privilege: must fault, but only after the edge.
        cfg_i = 8'h0B; match_i = 1'b1; acc_i = 3'b100; priv_m_i = 1'b0;
        #1;
        check("R12", applies_o, fault_o, 1'b0, 1'b0);
        @(negedge clk);
        check("R12", applies_o, fault_o, 1'b1, 1'b1);
        apply(8'h00, 1'b0, 3'b000, 1'b0, "R12");
    endtask

    task automatic t_directed;
        apply(8'h1B, 1'b1, 3'b100, 1'b0, "R1");   // NAPOT, RW, no X
        apply(8'h1D, 1'b1, 3'b010, 1'b0, "R2");   // NAPOT, RX, no W
        apply(8'h0E, 1'b1, 3'b001, 1'b0, "R3");   // TOR, WX, no R
        apply(8'h0F, 1'b1, 3'b010, 1'b0, "R4");
        apply(8'h88, 1'b1, 3'b001, 1'b0, "R5");   // locked, lower priv
        apply(8'h08, 1'b1, 3'b001, 1'b1, "R6");   // unlocked, machine
        apply(8'h98, 1'b1, 3'b100, 1'b1, "R7");   // locked, machine, no X
        apply(8'h07, 1'b1, 3'b001, 1'b0, "R8");
        apply(8'h18, 1'b0, 3'b001, 1'b0, "R9");
        apply(8'h18, 1'b1, 3'b011, 1'b0, "R10");
        apply(8'h18, 1'b1, 3'b000, 1'b0, "R10");
        apply(8'h78, 1'b1, 3'b100, 1'b0, "R11");  // reserved bits set
    endtask

    task automatic t_sweep;
        for (int c = 0; c < 256; c++) begin
            for (int m = 0; m < 2; m++) begin
                for (int a = 0; a < 8; a++) begin
                    for (int p = 0; p < 2; p++) begin
                        apply(8'(c), 1'(m), 3'(a), 1'(p),
                              (c[6:5] != 2'b00) ? "R11" : tag_of(8'(c), 1'(m), 3'(a), 1'(p)));
                    end
                end
            end
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_latency();
        t_directed();
        t_sweep();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end
endmodule